// File: doc/BRIEF.md
# Interrupt Wake-Up and Dispatch Qualifier

This block sits beside a processor core and decides two things each cycle: whether the pending interrupt requests should wake the core out of a low-power state, and whether a service routine should be dispatched while the core runs. It handles a group of maskable requests that share one global mask, and one special request with a mask of its own. Each maskable request has an enable bit, a 3-bit priority level and a flag that says whether its source can assert without a running clock.

In run mode the block issues a one-cycle dispatch strobe with the chosen request index. It then sets the global mask, saves the current priority level on a small stack and raises the level to that of the dispatched request. A return strobe restores the saved level. In wait or stop mode it issues a one-cycle wake pulse through a two-flop synchronizer. When the special request wakes the core while its mask is set, the wake pulse comes with a resume indication so that execution continues without any service routine.

Top module: `irq_wake_qual`

## Requirements
- R1: After reset the global mask reads 1, the current level reads 0, the level stack is empty, and the wake, resume and dispatch outputs are low.
- R2: Maskable request k qualifies only if its request bit and its enable bit are both 1, the global mask is 0, and its level (`lvl_i[3k+2:3k]`) is strictly greater than the current level.
- R3: Among qualified requests the one with the highest level is chosen. When levels tie, the lowest index wins.
- R4: In run mode, a qualified request makes `disp_o` high for exactly one cycle after the next clock edge, with `disp_idx_o` set to k. On the same edge the global mask becomes 1, the old level is pushed, and the current level becomes the request's level.
- R5: Once the mask is cleared during service, a pending request at the same level as the current one is not dispatched, and a request at a higher level is dispatched.
- R6: `ret_i` pops the stack into the current level and clears the global mask. A return with the stack empty leaves the level at 0.
- R7: While the stack holds 4 entries, no further dispatch takes place.
- R8: In wait mode (`mode_i`=1), a qualified request or the special request produces a one-cycle `wake_o`. While the global mask is 1, maskable requests produce no wake.
- R9: In stop mode (`mode_i`=2), only qualified requests whose `async_i` bit is 1, or the special request, produce a wake. Requests from clocked sources are ignored.
- R10: The special request wakes the core from wait or stop whatever the state of `xmask_i`. `resume_o` pulses together with `wake_o` only if `xmask_i` is 1 and no maskable request caused the wake.
- R11: In run mode the special request is dispatched with index 8, ahead of any maskable request. This happens only if `xmask_i` is 0 and the current level is below 7, and the level then becomes 7. With `xmask_i` at 1 there is no dispatch.
- R12: There is no dispatch outside run mode (`mode_i`=0), and there is no wake in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Maskable request lines |
| en_i | input | 8 | Per-request enable |
| async_i | input | 8 | 1 marks a source that can assert without a clock |
| lvl_i | input | 24 | 3-bit level per request, request k at [3k+2:3k] |
| xreq_i | input | 1 | Special request |
| xmask_i | input | 1 | Mask of the special request |
| cli_i | input | 1 | Clear global mask |
| sei_i | input | 1 | Set global mask |
| ret_i | input | 1 | Return from service, pops the level |
| mode_i | input | 2 | 0 run, 1 wait, 2 stop |
| wake_o | output | 1 | One-cycle wake pulse |
| resume_o | output | 1 | Wake without service |
| disp_o | output | 1 | One-cycle dispatch strobe |
| disp_idx_o | output | 4 | Dispatched index, 8 for the special request |
| imask_o | output | 1 | Global mask state |
| cur_lvl_o | output | 3 | Current priority level |

## Verification
The hardest state to reach is a full level stack, with a higher-level request still pending and the mask cleared. Getting there takes four nested dispatches, each with its own rising level, each followed by a mask clear. The bench builds that chain one request at a time and drops each request as soon as its dispatch is seen. It does the same for preemption: a request at the same level is raised and left standing before a higher one arrives. In this way the one refused dispatch and the one accepted dispatch are each seen on their own in the event stream.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

    localparam int NREQ_DEF  = 8;
    localparam int LVL_W_DEF = 3;
    localparam int STK_DEF   = 4;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pm_t;

    typedef struct packed {
        logic wake;
        logic resume;
    } wake_info_t;

    function automatic logic is_low_power(input pm_t m);
        return (m == PM_WAIT) || (m == PM_STOP);
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = irq_qual_pkg::NREQ_DEF,
    parameter int LW = irq_qual_pkg::LVL_W_DEF,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N*LW-1:0] lvl_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o,
    output logic [LW-1:0]   lvl_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_i[i] && (!any_o || lvl_i[i*LW +: LW] >= lvl_o)) begin
                any_o = 1'b1;
                idx_o = IW'(i);
                lvl_o = lvl_i[i*LW +: LW];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int LW    = irq_qual_pkg::LVL_W_DEF,
    parameter int DEPTH = irq_qual_pkg::STK_DEF,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] din_i,
    output logic [LW-1:0] top_o,
    output logic          full_o
);
    logic [LW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] cm1;

    assign cm1    = cnt - CW'(1);
    assign full_o = (cnt == CW'(DEPTH));
    assign top_o  = (cnt == '0) ? '0 : mem[cm1[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_i && !full_o) begin
            mem[cnt[PW-1:0]] <= din_i;
            cnt <= cnt + CW'(1);
        end else if (pop_i && cnt != '0) begin
            cnt <= cm1;
        end
    end

    // R7
    stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R6
    stack_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/irq_wake_sync.sv
module irq_wake_sync
    import irq_qual_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wake_info_t raw_i,
    output logic       wake_o,
    output logic       resume_o
);
    wake_info_t s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= raw_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign wake_o   = s2.wake & ~s3.wake;
    assign resume_o = wake_o & s2.resume;

    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);
endmodule

// File: rtl/irq_wake_qual.sv
module irq_wake_qual
    import irq_qual_pkg::*;
#(
    parameter int N     = NREQ_DEF,
    parameter int LW    = LVL_W_DEF,
    parameter int DEPTH = STK_DEF,
    localparam int IW  = $clog2(N + 1),
    localparam int PIW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  en_i,
    input  logic [N-1:0]  async_i,
    input  logic [N*LW-1:0] lvl_i,
    input  logic          xreq_i,
    input  logic          xmask_i,
    input  logic          cli_i,
    input  logic          sei_i,
    input  logic          ret_i,
    input  logic [1:0]    mode_i,
    output logic          wake_o,
    output logic          resume_o,
    output logic          disp_o,
    output logic [IW-1:0] disp_idx_o,
    output logic          imask_o,
    output logic [LW-1:0] cur_lvl_o
);
    localparam logic [LW-1:0] LVL_MAX = '1;

    pm_t mode;
    assign mode = pm_t'(mode_i);

    logic [N-1:0] qual;
    for (genvar k = 0; k < N; k++) begin : g_qual
        assign qual[k] = req_i[k] & en_i[k] & ~imask_o
                       & (lvl_i[k*LW +: LW] > cur_lvl_o);
    end

    logic           pk_any;
    logic [PIW-1:0] pk_idx;
    logic [LW-1:0]  pk_lvl;

    irq_prio_pick #(.N(N), .LW(LW)) u_pick (
        .valid_i (qual),
        .lvl_i   (lvl_i),
        .any_o   (pk_any),
        .idx_o   (pk_idx),
        .lvl_o   (pk_lvl)
    );

    logic          stk_full;
    logic [LW-1:0] stk_top;
    logic          x_take, m_take, take;

    assign x_take = xreq_i & ~xmask_i & (cur_lvl_o != LVL_MAX) & ~stk_full;
    assign m_take = pk_any & ~stk_full;
    assign take   = (mode == PM_RUN) & (x_take | m_take);

    irq_lvl_stack #(.LW(LW), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push_i (take),
        .pop_i  (ret_i & ~take),
        .din_i  (cur_lvl_o),
        .top_o  (stk_top),
        .full_o (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imask_o    <= 1'b1;
            cur_lvl_o  <= '0;
            disp_o     <= 1'b0;
            disp_idx_o <= '0;
        end else begin
            disp_o <= 1'b0;
            if (take) begin
                disp_o     <= 1'b1;
                imask_o    <= 1'b1;
                disp_idx_o <= x_take ? IW'(N) : IW'(pk_idx);
                cur_lvl_o  <= x_take ? LVL_MAX : pk_lvl;
            end else if (ret_i) begin
                cur_lvl_o <= stk_top;
                imask_o   <= 1'b0;
            end else if (cli_i) begin
                imask_o <= 1'b0;
            end else if (sei_i) begin
                imask_o <= 1'b1;
            end
        end
    end

    // Wake qualification: stop mode sees only asynchronous sources.
    logic       any_mode;
    wake_info_t raw;

    always_comb begin
        unique case (mode)
            PM_WAIT: any_mode = |qual;
            PM_STOP: any_mode = |(qual & async_i);
            default: any_mode = 1'b0;
        endcase
        raw.wake   = is_low_power(mode) & (any_mode | xreq_i);
        raw.resume = is_low_power(mode) & xreq_i & xmask_i & ~any_mode;
    end

    irq_wake_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (raw),
        .wake_o   (wake_o),
        .resume_o (resume_o)
    );

    // R4
    disp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        disp_o |=> !disp_o);

    // R4
    disp_mask_chk: assert property (@(posedge clk) disable iff (rst)
        disp_o |-> imask_o);

    // R5
    disp_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        disp_o |-> (cur_lvl_o > $past(cur_lvl_o)));

    // R12
    disp_run_chk: assert property (@(posedge clk) disable iff (rst)
        disp_o |-> ($past(mode_i) == PM_RUN));

    // R10
    resume_wake_chk: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> wake_o);
endmodule

// File: tb/sim_irq_wake_qual.sv
module sim_irq_wake_qual;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  req, en, asy;
    logic [23:0] lvl;
    logic        xreq, xmask, cli, sei, ret;
    logic [1:0]  mode;
    logic        wake, resume, disp, imask;
    logic [3:0]  didx;
    logic [2:0]  cur;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       w;
        logic       r;
        logic       d;
        logic [3:0] idx;
        string      tag;
    } ev_t;
    ev_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wake_qual u0 (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .async_i(asy),
        .lvl_i(lvl), .xreq_i(xreq), .xmask_i(xmask), .cli_i(cli),
        .sei_i(sei), .ret_i(ret), .mode_i(mode), .wake_o(wake),
        .resume_o(resume), .disp_o(disp), .disp_idx_o(didx),
        .imask_o(imask), .cur_lvl_o(cur)
    );

    // Monitor: compares every observed event with the head of the queue.
    always @(negedge clk) begin
        if (!rst && (wake || resume || disp)) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected event: actual w%0b r%0b d%0b idx%0d expected none",
                         wake, resume, disp, didx);
            end else begin
                ev_t e;
                e = q.pop_front();
                if (e.w !== wake || e.r !== resume || e.d !== disp ||
                    (e.d && e.idx !== didx)) begin
                    fails++;
                    $display("FAIL %s: actual w%0b r%0b d%0b idx%0d expected w%0b r%0b d%0b idx%0d",
                             e.tag, wake, resume, disp, didx, e.w, e.r, e.d, e.idx);
                end
            end
        end
    end

    task automatic expect_ev(input logic w, input logic r, input logic d,
                             input logic [3:0] idx, input string tag);
        ev_t e;
        e.w = w; e.r = r; e.d = d; e.idx = idx; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drained(input string tag);
        chk({tag, " pending events"}, q.size(), 0);
        q.delete();
    endtask

    task automatic pulse_cli(); cli = 1'b1; cyc(1); cli = 1'b0; endtask
    task automatic pulse_sei(); sei = 1'b1; cyc(1); sei = 1'b0; endtask
    task automatic pulse_ret(); ret = 1'b1; cyc(1); ret = 1'b0; endtask

    task automatic setl(input int k, input logic [2:0] v);
        lvl[k*3 +: 3] = v;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req = '0; en = '1; asy = 8'b0100_0000; lvl = '0;
        xreq = 0; xmask = 0; cli = 0; sei = 0; ret = 0; mode = 2'd0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 imask", imask, 1);
        chk("R1 level", cur, 0);
        chk("R1 disp", disp, 0);
        chk("R1 wake", wake, 0);
        cyc(3);
        drained("R1");

        // R4 basic dispatch
        pulse_cli();
        expect_ev(0, 0, 1, 0, "R4 dispatch idx0");
        setl(0, 3'd2); req[0] = 1'b1;
        cyc(3);
        drained("R4");
        chk("R4 level raised", cur, 2);
        chk("R4 mask set", imask, 1);
        req[0] = 1'b0;

        // R5 equal level does not preempt, higher does
        setl(2, 3'd2); req[2] = 1'b1;
        pulse_cli();
        cyc(4);
        drained("R5 equal level");
        expect_ev(0, 0, 1, 1, "R5 higher preempts");
        setl(1, 3'd5); req[1] = 1'b1;
        cyc(3);
        drained("R5 higher");
        chk("R5 level", cur, 5);
        req[1] = 1'b0;

        // R6 returns restore levels
        pulse_ret();
        cyc(3);
        drained("R6 first return");
        chk("R6 restored level", cur, 2);
        expect_ev(0, 0, 1, 2, "R6 pending after unwind");
        pulse_ret();
        cyc(3);
        drained("R6 second return");
        chk("R6 level after redispatch", cur, 2);
        req[2] = 1'b0;
        pulse_ret();
        pulse_ret();
        pulse_ret();
        chk("R6 empty pop level", cur, 0);
        chk("R6 mask cleared", imask, 0);

        // R2 masked and disabled requests; R3 tie to lowest index
        pulse_sei();
        setl(3, 3'd4); setl(5, 3'd4); setl(1, 3'd3); setl(7, 3'd7);
        en[7] = 1'b0;
        req[1] = 1; req[3] = 1; req[5] = 1; req[7] = 1;
        cyc(4);
        drained("R2 masked");
        expect_ev(0, 0, 1, 3, "R3 tie lowest index");
        pulse_cli();
        cyc(3);
        drained("R3");
        chk("R3 level", cur, 4);
        req = '0; en = '1;
        pulse_ret();
        cyc(2);

        // R7 stack depth
        for (int v = 1; v <= 4; v++) begin
            expect_ev(0, 0, 1, 4'(v), "R7 nesting");
            setl(v, 3'(v)); req[v] = 1'b1;
            pulse_cli();
            cyc(3);
            req[v] = 1'b0;
        end
        drained("R7 nest");
        setl(5, 3'd6); req[5] = 1'b1;
        pulse_cli();
        cyc(4);
        drained("R7 full blocks");
        chk("R7 level held", cur, 4);
        req[5] = 1'b0;
        for (int i = 0; i < 4; i++) pulse_ret();
        chk("R7 unwound", cur, 0);

        // R8 wait mode: masked then unmasked
        pulse_sei();
        mode = 2'd1;
        setl(0, 3'd3); req[0] = 1'b1;
        cyc(8);
        drained("R8 masked no wake");
        expect_ev(1, 0, 0, 0, "R8 wake");
        pulse_cli();
        cyc(6);
        drained("R8 wake");
        expect_ev(0, 0, 1, 0, "R12 dispatch only in run");
        mode = 2'd0;
        cyc(3);
        drained("R12");
        req[0] = 1'b0;
        pulse_ret();

        // R9 stop mode: clocked source ignored, async source wakes
        mode = 2'd2;
        setl(4, 3'd3); req[4] = 1'b1;
        cyc(8);
        drained("R9 clocked ignored");
        expect_ev(1, 0, 0, 0, "R9 async wake");
        setl(6, 3'd2); req[6] = 1'b1;
        cyc(6);
        drained("R9 async");
        expect_ev(0, 0, 1, 4, "R3 after stop");
        mode = 2'd0;
        cyc(3);
        drained("R9 run");
        chk("R9 level", cur, 3);
        req = '0;
        pulse_ret();

        // R10 X wake with mask set: resume, no dispatch in run
        xmask = 1'b1;
        mode = 2'd2;
        expect_ev(1, 1, 0, 0, "R10 resume wake");
        xreq = 1'b1;
        cyc(6);
        drained("R10 masked");
        mode = 2'd0;
        cyc(5);
        drained("R11 masked no dispatch");
        xreq = 1'b0;

        // R10 X wake with mask clear, then R11 dispatch
        xmask = 1'b0;
        mode = 2'd1;
        expect_ev(1, 0, 0, 0, "R10 wake no resume");
        xreq = 1'b1;
        cyc(6);
        drained("R10 clear");
        expect_ev(0, 0, 1, 8, "R11 special dispatch");
        mode = 2'd0;
        cyc(3);
        drained("R11");
        chk("R11 level max", cur, 7);
        cyc(3);
        drained("R11 no repeat");
        xreq = 1'b0;
        pulse_ret();

        // R11 special wins over a pending maskable
        pulse_sei();
        setl(3, 3'd6); req[3] = 1'b1;
        expect_ev(0, 0, 1, 8, "R11 priority");
        xreq = 1'b1;
        cyc(3);
        drained("R11 priority");
        xreq = 1'b0;
        expect_ev(0, 0, 1, 3, "R6 maskable after return");
        pulse_ret();
        cyc(3);
        drained("R6 after special");
        chk("R6 level", cur, 6);
        req = '0;
        pulse_ret();
        cyc(3);
        drained("end");

        summary();
        $finish;
    end
endmodule